// File: doc/BRIEF.md
# Power-Fail Event Ring Logger

This block sits between a rail-monitoring front end and a non-volatile store. Every cycle it may receive one rail event carrying a rail number, an event class, a severity and a status byte. Every event bumps a saturating occurrence counter kept per rail and per class. Only events whose severity reaches a programmable threshold are turned into records. A record holds the rail, class, severity, status, the counter value after the bump and a millisecond timestamp. Records are kept in an on-chip ring. Slot zero of the ring is pinned to an identity header (hardware version, firmware version, serial number) that is captured once after reset and never rewritten.

When the early power-fail warning rises, the block drains the ring to a simple write port with no back-pressure. The header goes out first, then the pending records, oldest first, one per cycle. Words are grouped into batches. The whole flush is bounded by a cycle budget. Events that arrive during a flush are appended behind it and drained in the same flush, unless the ring is full. A flush that runs out of budget stops, raises a truncation flag and reports how many records were still pending.

Top module: `fruRingLogger`

## Requirements
- R1: While reset is asserted, and right after it, wrValid, wrBatchEnd, flushBusy, flushDone and truncated are 0 and lostCount is 0.
- R2: An event whose severity is below sevThreshold (unsigned compare) updates its counter but produces no record. An event at or above the threshold produces one record.
- R3: Each valid event increments the counter for its (rail, class) pair. The counter saturates at 2^CNT_W-1 and never wraps. The record carries the value after the increment.
- R4: A millisecond counter starts at 0 on reset and increments once every TICK_DIV cycles. A record's timestamp is the value of this counter at the clock edge that samples the event.
- R5: An event record is REC_W bits wide with bit REC_W-1 = 0. From bit 0 upward it holds: timestamp (32 bits), counter (CNT_W), status, severity, class and rail, with zero padding above. The header word has bit REC_W-1 = 1 and holds, from bit 0 upward: hwVersion, fwVersion and serialNum.
- R6: Outside a flush, logging into a full ring discards the oldest pending record. The ring therefore keeps the most recent DEPTH-1 pending records.
- R7: The header is taken from the identity inputs on the first clock after reset. It is the first word of every flush, and later changes on the identity inputs do not alter it.
- R8: A flush starts on a rising pfWarn sampled while idle. The header appears on the write port in the next cycle.
- R9: After the header, pending records are written oldest first, one per cycle. The flush ends, with flushDone set, at the first drain cycle that finds nothing pending.
- R10: wrBatchEnd marks every BATCH-th word of a flush, counting the header as word 1.
- R11: Words are written only in the first BUDGET cycles of a flush. If records are still pending once the budget is used up, the flush stops, truncated is set, and lostCount holds the number of records left pending.
- R12: A qualifying event that arrives during a flush is appended behind the pending records and drained in the same flush. It is dropped if the ring is full at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtValid | input | 1 | Event present this cycle |
| evtRail | input | RAIL_W | Rail number |
| evtClass | input | CLS_W | Event class |
| evtSev | input | SEV_W | Event severity |
| evtStatus | input | STAT_W | Status bits |
| sevThreshold | input | SEV_W | Minimum severity that gets logged |
| hwVersion | input | HW_W | Hardware version for the header |
| fwVersion | input | FW_W | Firmware version for the header |
| serialNum | input | SN_W | Board serial number for the header |
| pfWarn | input | 1 | Early power-fail warning |
| wrValid | output | 1 | Write word valid |
| wrData | output | REC_W | Write word (header or record) |
| wrBatchEnd | output | 1 | Last word of a batch |
| flushBusy | output | 1 | Flush in progress |
| flushDone | output | 1 | Last flush drained everything |
| truncated | output | 1 | Last flush ran out of budget |
| lostCount | output | PEND_W | Records left pending by a truncated flush |

## Verification
The assertions assume that rail and class numbers stay inside NUM_RAILS and NUM_CLASSES. They also assume that the identity inputs are valid on the first clock after reset. The bench holds these inputs stable through reset, and later changes them only to show that the header stays unchanged. pfWarn is held low between warnings so that each warning yields one clean rising edge. A behavioural model built on a queue follows every clock and predicts the write port. The scenarios fill the ring past capacity, flush into the budget limit, and inject events both into a draining ring and into a full one.

// File: rtl/fruLogPkg.sv
package fruLogPkg;

  typedef enum logic [1:0] {
    FL_IDLE  = 2'd0,
    FL_HDR   = 2'd1,
    FL_DRAIN = 2'd2
  } flushState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHdr;
    logic countEvt;
    logic pushEvt;
    logic dropOldest;
    logic popEvt;
    logic selHdr;
  } logStrobe_t;

endpackage

// File: rtl/fruLogDatapath.sv
module fruLogDatapath
  import fruLogPkg::*;
#(
  parameter int NUM_RAILS   = 4,
  parameter int NUM_CLASSES = 4,
  parameter int SEV_W       = 3,
  parameter int STAT_W      = 8,
  parameter int CNT_W       = 7,
  parameter int DEPTH       = 256,
  parameter int TICK_DIV    = 50000,
  parameter int HW_W        = 8,
  parameter int FW_W        = 8,
  parameter int SN_W        = 32,
  localparam int TS_W   = 32,
  localparam int RAIL_W = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1,
  localparam int CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int EVT_W  = TS_W + CNT_W + STAT_W + SEV_W + CLS_W + RAIL_W,
  localparam int HDR_W  = HW_W + FW_W + SN_W,
  localparam int BODY_W = (EVT_W > HDR_W) ? EVT_W : HDR_W,
  localparam int REC_W  = BODY_W + 1,
  localparam int PEND_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobe_t        stb,
  input  logic [RAIL_W-1:0] evtRail,
  input  logic [CLS_W-1:0]  evtClass,
  input  logic [SEV_W-1:0]  evtSev,
  input  logic [STAT_W-1:0] evtStatus,
  input  logic [HW_W-1:0]   hwVersion,
  input  logic [FW_W-1:0]   fwVersion,
  input  logic [SN_W-1:0]   serialNum,
  output logic [PEND_W-1:0] pendCount,
  output logic [REC_W-1:0]  wrData
);

  localparam int EV_SLOTS = DEPTH - 1;
  localparam int PTR_W    = (EV_SLOTS > 1) ? $clog2(EV_SLOTS) : 1;
  localparam int PHY_W    = $clog2(DEPTH);
  localparam int TOTAL    = NUM_RAILS * NUM_CLASSES;
  localparam int DIV_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [REC_W-1:0]  ringMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [PEND_W-1:0] pend, pendNext;
  logic [CNT_W-1:0]  occCnt [TOTAL];
  logic [CNT_W-1:0]  curCnt, nextCnt;
  logic [DIV_W-1:0]  preCnt;
  logic [TS_W-1:0]   msCount;
  logic [REC_W-1:0]  evtRec, hdrRec;
  logic [PHY_W-1:0]  wrPhy, rdPhy;
  int                cntSel;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(EV_SLOTS - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  // counter lookup and record build
  always_comb begin
    cntSel = int'(evtRail) * NUM_CLASSES + int'(evtClass);
    curCnt = '0;
    for (int i = 0; i < TOTAL; i++) begin
      if (i == cntSel) curCnt = occCnt[i];
    end
    nextCnt = (curCnt == CNT_MAX) ? curCnt : curCnt + CNT_W'(1);
    evtRec  = REC_W'({evtRail, evtClass, evtSev, evtStatus, nextCnt, msCount});
    hdrRec  = {1'b1, BODY_W'({serialNum, fwVersion, hwVersion})};
    wrPhy   = PHY_W'(wrPtr) + PHY_W'(1);
    rdPhy   = PHY_W'(rdPtr) + PHY_W'(1);
    pendNext = pend + PEND_W'(stb.pushEvt && !stb.dropOldest) - PEND_W'(stb.popEvt);
    wrData   = stb.selHdr ? ringMem[0] : ringMem[rdPhy];
    pendCount = pend;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TOTAL; i++) occCnt[i] <= '0;
    end else if (stb.countEvt) begin
      for (int i = 0; i < TOTAL; i++) begin
        if (i == cntSel) occCnt[i] <= nextCnt;
      end
    end
  end

  // ring storage, slot 0 pinned to header
  always_ff @(posedge clk) begin
    if (stb.loadHdr) ringMem[0] <= hdrRec;
    if (stb.pushEvt) ringMem[wrPhy] <= evtRec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      pend  <= '0;
    end else begin
      if (stb.pushEvt) wrPtr <= bumpPtr(wrPtr);
      if (stb.popEvt || stb.dropOldest) rdPtr <= bumpPtr(rdPtr);
      pend <= pendNext;
    end
  end

  // millisecond time base
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      msCount <= '0;
    end else if (preCnt == DIV_W'(TICK_DIV - 1)) begin
      preCnt  <= '0;
      msCount <= msCount + TS_W'(1);
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end

  a_r6_pend_bound: assert property (@(posedge clk) disable iff (!rstN)
    pend <= PEND_W'(EV_SLOTS));
  a_r6_drop_only_full: assert property (@(posedge clk) disable iff (!rstN)
    stb.dropOldest |-> (pend == PEND_W'(EV_SLOTS)));
  a_r12_no_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    stb.popEvt |-> (pend != '0));
  a_r4_ms_step: assert property (@(posedge clk) disable iff (!rstN)
    (msCount == $past(msCount)) || (msCount == $past(msCount) + TS_W'(1)));
  a_r7_hdr_marked: assert property (@(posedge clk) disable iff (!rstN)
    (stb.selHdr && !stb.loadHdr) |-> wrData[REC_W-1]);

  for (genvar g = 0; g < TOTAL; g++) begin : gCntChk
    a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rstN)
      ($past(occCnt[g]) == CNT_MAX) |-> (occCnt[g] == CNT_MAX));
    a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
      (occCnt[g] == $past(occCnt[g])) || (occCnt[g] == $past(occCnt[g]) + CNT_W'(1)));
  end

endmodule

// File: rtl/fruLogControl.sv
module fruLogControl
  import fruLogPkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int BATCH  = 8,
  parameter int BUDGET = 300,
  parameter int SEV_W  = 3,
  localparam int PEND_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [SEV_W-1:0]  evtSev,
  input  logic [SEV_W-1:0]  sevThreshold,
  input  logic              pfWarn,
  input  logic [PEND_W-1:0] pendCount,
  output logStrobe_t        stb,
  output logic              wrValid,
  output logic              wrBatchEnd,
  output logic              flushBusy,
  output logic              flushDone,
  output logic              truncated,
  output logic [PEND_W-1:0] lostCount
);

  localparam int EV_SLOTS = DEPTH - 1;
  localparam int BATCH_W  = (BATCH > 1) ? $clog2(BATCH) : 1;
  localparam int BUD_W    = $clog2(BUDGET + 1);

  flushState_t        state;
  logic               pfPrev, hdrLoaded;
  logic [BUD_W-1:0]   cycCnt;
  logic [BATCH_W-1:0] wordIdx, wordIdxBump;
  logic flushing, full, pendZero, inBudget, accept, startFlush;

  always_comb begin
    flushing   = (state != FL_IDLE);
    full       = (pendCount == PEND_W'(EV_SLOTS));
    pendZero   = (pendCount == '0);
    inBudget   = (cycCnt < BUD_W'(BUDGET));
    accept     = evtValid && (evtSev >= sevThreshold) && !(flushing && full);
    startFlush = pfWarn && !pfPrev && !flushing;
    wordIdxBump = (wordIdx == BATCH_W'(BATCH - 1)) ? '0 : wordIdx + BATCH_W'(1);

    stb            = '0;
    stb.loadHdr    = !hdrLoaded;
    stb.countEvt   = evtValid;
    stb.pushEvt    = accept;
    stb.dropOldest = accept && !flushing && full;
    stb.popEvt     = (state == FL_DRAIN) && !pendZero && inBudget;
    stb.selHdr     = (state == FL_HDR);

    wrValid    = stb.selHdr || stb.popEvt;
    wrBatchEnd = wrValid && (wordIdx == BATCH_W'(BATCH - 1));
    flushBusy  = flushing;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= FL_IDLE;
      pfPrev    <= 1'b0;
      hdrLoaded <= 1'b0;
      cycCnt    <= '0;
      wordIdx   <= '0;
      flushDone <= 1'b0;
      truncated <= 1'b0;
      lostCount <= '0;
    end else begin
      pfPrev    <= pfWarn;
      hdrLoaded <= 1'b1;
      case (state)
        FL_IDLE: begin
          if (startFlush) begin
            state     <= FL_HDR;
            cycCnt    <= '0;
            wordIdx   <= '0;
            flushDone <= 1'b0;
            truncated <= 1'b0;
            lostCount <= '0;
          end
        end
        FL_HDR: begin
          state   <= FL_DRAIN;
          cycCnt  <= cycCnt + BUD_W'(1);
          wordIdx <= wordIdxBump;
        end
        FL_DRAIN: begin
          if (pendZero) begin
            state     <= FL_IDLE;
            flushDone <= 1'b1;
          end else if (!inBudget) begin
            state     <= FL_IDLE;
            truncated <= 1'b1;
            lostCount <= pendCount + PEND_W'(accept);
          end else begin
            cycCnt  <= cycCnt + BUD_W'(1);
            wordIdx <= wordIdxBump;
          end
        end
        default: state <= FL_IDLE;
      endcase
    end
  end

  a_r11_trunc_has_loss: assert property (@(posedge clk) disable iff (!rstN)
    $rose(truncated) |-> (lostCount != '0));
  a_r9_outcome_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(flushDone && truncated));
  a_r8_header_next: assert property (@(posedge clk) disable iff (!rstN)
    startFlush |=> (wrValid && stb.selHdr));
  a_r12_push_room: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pushEvt && flushing) |-> (pendCount != PEND_W'(EV_SLOTS)));

endmodule

// File: rtl/fruRingLogger.sv
module fruRingLogger
  import fruLogPkg::*;
#(
  parameter int NUM_RAILS   = 4,
  parameter int NUM_CLASSES = 4,
  parameter int SEV_W       = 3,
  parameter int STAT_W      = 8,
  parameter int CNT_W       = 7,
  parameter int DEPTH       = 256,
  parameter int BATCH       = 8,
  parameter int BUDGET      = 300,
  parameter int TICK_DIV    = 50000,
  parameter int HW_W        = 8,
  parameter int FW_W        = 8,
  parameter int SN_W        = 32,
  localparam int RAIL_W = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1,
  localparam int CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int EVT_W  = 32 + CNT_W + STAT_W + SEV_W + CLS_W + RAIL_W,
  localparam int HDR_W  = HW_W + FW_W + SN_W,
  localparam int REC_W  = ((EVT_W > HDR_W) ? EVT_W : HDR_W) + 1,
  localparam int PEND_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [RAIL_W-1:0] evtRail,
  input  logic [CLS_W-1:0]  evtClass,
  input  logic [SEV_W-1:0]  evtSev,
  input  logic [STAT_W-1:0] evtStatus,
  input  logic [SEV_W-1:0]  sevThreshold,
  input  logic [HW_W-1:0]   hwVersion,
  input  logic [FW_W-1:0]   fwVersion,
  input  logic [SN_W-1:0]   serialNum,
  input  logic              pfWarn,
  output logic              wrValid,
  output logic [REC_W-1:0]  wrData,
  output logic              wrBatchEnd,
  output logic              flushBusy,
  output logic              flushDone,
  output logic              truncated,
  output logic [PEND_W-1:0] lostCount
);

  logStrobe_t        stb;
  logic [PEND_W-1:0] pendCount;

  fruLogControl #(
    .DEPTH(DEPTH), .BATCH(BATCH), .BUDGET(BUDGET), .SEV_W(SEV_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtSev(evtSev),
    .sevThreshold(sevThreshold), .pfWarn(pfWarn), .pendCount(pendCount),
    .stb(stb), .wrValid(wrValid), .wrBatchEnd(wrBatchEnd),
    .flushBusy(flushBusy), .flushDone(flushDone), .truncated(truncated),
    .lostCount(lostCount)
  );

  fruLogDatapath #(
    .NUM_RAILS(NUM_RAILS), .NUM_CLASSES(NUM_CLASSES), .SEV_W(SEV_W),
    .STAT_W(STAT_W), .CNT_W(CNT_W), .DEPTH(DEPTH), .TICK_DIV(TICK_DIV),
    .HW_W(HW_W), .FW_W(FW_W), .SN_W(SN_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .evtRail(evtRail),
    .evtClass(evtClass), .evtSev(evtSev), .evtStatus(evtStatus),
    .hwVersion(hwVersion), .fwVersion(fwVersion), .serialNum(serialNum),
    .pendCount(pendCount), .wrData(wrData)
  );

endmodule

// File: tb/fruRingLogger_tb.sv
module fruRingLogger_tb;

  localparam int NR = 4, NC = 4, SEVW = 3, STW = 8, CW = 3;
  localparam int DEP = 8, BAT = 3, BUD = 6, TDIV = 4;
  localparam int SLOTS = DEP - 1;
  localparam int EVW = 32 + CW + STW + SEVW + 2 + 2;
  localparam int HDW = 8 + 8 + 32;
  localparam int RW = ((EVW > HDW) ? EVW : HDW) + 1;
  localparam int PW = $clog2(DEP);

  logic clk = 1'b0;
  logic rstN;
  logic evtValid;
  logic [1:0] evtRail, evtClass;
  logic [SEVW-1:0] evtSev, sevThreshold;
  logic [STW-1:0] evtStatus;
  logic [7:0] hwVersion, fwVersion;
  logic [31:0] serialNum;
  logic pfWarn;
  logic wrValid, wrBatchEnd, flushBusy, flushDone, truncated;
  logic [RW-1:0] wrData;
  logic [PW-1:0] lostCount;

  always #10 clk = ~clk;

  fruRingLogger #(
    .NUM_RAILS(NR), .NUM_CLASSES(NC), .SEV_W(SEVW), .STAT_W(STW), .CNT_W(CW),
    .DEPTH(DEP), .BATCH(BAT), .BUDGET(BUD), .TICK_DIV(TDIV)
  ) u_dut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtRail(evtRail),
    .evtClass(evtClass), .evtSev(evtSev), .evtStatus(evtStatus),
    .sevThreshold(sevThreshold), .hwVersion(hwVersion), .fwVersion(fwVersion),
    .serialNum(serialNum), .pfWarn(pfWarn), .wrValid(wrValid), .wrData(wrData),
    .wrBatchEnd(wrBatchEnd), .flushBusy(flushBusy), .flushDone(flushDone),
    .truncated(truncated), .lostCount(lostCount)
  );

  int checks = 0, errors = 0;
  string curTag = "R1";

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  int mState = 0;
  logic [RW-1:0] q[$];
  logic [RW-1:0] mHdr;
  bit mHdrDone = 0;
  int mCnt[NR*NC];
  int unsigned mMs = 0;
  int mPre = 0, mCyc = 0, mIdx = 0, mLost = 0;
  bit mTrunc = 0, mDone = 0, mPfPrev = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; q.delete(); mHdrDone = 0; mMs = 0; mPre = 0; mCyc = 0;
      mIdx = 0; mLost = 0; mTrunc = 0; mDone = 0; mPfPrev = 0;
      for (int i = 0; i < NR*NC; i++) mCnt[i] = 0;
    end else begin
      int n0, sel, c;
      bit flushing, full, pop, valid, acc;
      logic [RW-1:0] rec;
      n0 = q.size();
      flushing = (mState != 0);
      full = (n0 == SLOTS);
      pop = (mState == 2) && (n0 > 0) && (mCyc < BUD);
      valid = (mState == 1) || pop;
      acc = 0;
      rec = '0;
      if (evtValid) begin
        sel = evtRail * NC + evtClass;
        c = (mCnt[sel] == (1 << CW) - 1) ? mCnt[sel] : mCnt[sel] + 1;
        mCnt[sel] = c;
        rec = RW'({evtRail, evtClass, evtSev, evtStatus, CW'(c), mMs});
        acc = (evtSev >= sevThreshold) && !(flushing && full);
      end
      if (pop) void'(q.pop_front());
      if (acc) begin
        if (!flushing && full) void'(q.pop_front());
        q.push_back(rec);
      end
      if (!mHdrDone) begin
        mHdr = {1'b1, (RW-1)'({serialNum, fwVersion, hwVersion})};
        mHdrDone = 1;
      end
      case (mState)
        0: if (pfWarn && !mPfPrev) begin
             mState = 1; mCyc = 0; mIdx = 0; mDone = 0; mTrunc = 0; mLost = 0;
           end
        1: begin mState = 2; mCyc++; mIdx = (mIdx + 1) % BAT; end
        default: begin
          if (n0 == 0) begin mState = 0; mDone = 1; end
          else if (mCyc >= BUD) begin mState = 0; mTrunc = 1; mLost = q.size(); end
          else begin mCyc++; if (valid) mIdx = (mIdx + 1) % BAT; end
        end
      endcase
      mPfPrev = pfWarn;
      if (mPre == TDIV - 1) begin mPre = 0; mMs++; end else mPre++;
    end
  end

  // per-cycle comparison and observation
  int wordCount = 0, firstCnt = -1, lastCnt = -1;
  logic [RW-1:0] lastHdr = '0;

  always @(negedge clk) begin
    if (rstN) begin
      bit eValid;
      logic [RW-1:0] eData;
      eValid = (mState == 1) || (mState == 2 && q.size() > 0 && mCyc < BUD);
      eData = (mState == 1) ? mHdr : ((q.size() > 0) ? q[0] : '0);
      chk(curTag, "wrValid (R9)", 64'(wrValid), 64'(eValid));
      chk(curTag, "flushBusy (R8)", 64'(flushBusy), 64'(mState != 0));
      chk(curTag, "wrBatchEnd (R10)", 64'(wrBatchEnd), 64'(eValid && mIdx == BAT - 1));
      chk(curTag, "flushDone (R9)", 64'(flushDone), 64'(mDone));
      chk(curTag, "truncated (R11)", 64'(truncated), 64'(mTrunc));
      chk(curTag, "lostCount (R11)", 64'(lostCount), 64'(mLost));
      if (eValid) chk(curTag, "wrData (R5)", 64'(wrData), 64'(eData));
      if (wrValid) begin
        if (wrData[RW-1]) lastHdr = wrData;
        else begin
          if (wordCount == 0) firstCnt = int'(wrData[32 +: CW]);
          lastCnt = int'(wrData[32 +: CW]);
          wordCount++;
        end
      end
    end
  end

  task automatic sendEvt(input int r, input int c, input int s, input int st);
    @(negedge clk);
    evtValid = 1'b1; evtRail = 2'(r); evtClass = 2'(c);
    evtSev = SEVW'(s); evtStatus = STW'(st);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evtValid = 1'b0;
    end
  endtask

  task automatic doFlush();
    @(negedge clk);
    evtValid = 1'b0; pfWarn = 1'b1;
    idle(14);
    pfWarn = 1'b0;
    idle(2);
  endtask

  task automatic startCount();
    wordCount = 0; firstCnt = -1; lastCnt = -1;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; evtValid = 1'b0; evtRail = '0; evtClass = '0; evtSev = '0;
    evtStatus = '0; sevThreshold = 3'd3; hwVersion = 8'hA5; fwVersion = 8'h3C;
    serialNum = 32'h1234_5678; pfWarn = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1", "wrValid", 64'(wrValid), 64'd0);
    chk("R1", "flushBusy", 64'(flushBusy), 64'd0);
    chk("R1", "wrBatchEnd", 64'(wrBatchEnd), 64'd0);
    chk("R1", "flushDone", 64'(flushDone), 64'd0);
    chk("R1", "truncated", 64'(truncated), 64'd0);
    chk("R1", "lostCount", 64'(lostCount), 64'd0);
    rstN = 1'b1;
    idle(2);
    chk("R1", "idle wrValid after reset", 64'(wrValid), 64'd0);

    // R2 threshold filter, R4 timestamps, R5 format, R10 batches
    curTag = "R2/R4/R5/R10";
    sendEvt(0, 0, 1, 8'h11); idle(2);
    sendEvt(1, 2, 5, 8'h22); idle(3);
    sendEvt(2, 1, 3, 8'h33); idle(1);
    sendEvt(3, 3, 2, 8'h44); idle(5);
    sendEvt(0, 0, 7, 8'h55); idle(1);
    startCount();
    doFlush();
    chk("R2", "records written above threshold", 64'(wordCount), 64'd3);
    chk("R2", "counter includes filtered event", 64'(lastCnt), 64'd2);
    chk("R8", "header value", 64'(lastHdr), 64'({1'b1, (RW-1)'({32'h1234_5678, 8'h3C, 8'hA5})}));

    // R3 saturation, R6 roll-over, R11 truncation
    curTag = "R3/R6/R11";
    for (int i = 0; i < 10; i++) sendEvt(1, 1, 6, i);
    idle(1);
    startCount();
    doFlush();
    chk("R11", "truncated", 64'(truncated), 64'd1);
    chk("R11", "lostCount", 64'(lostCount), 64'd2);
    chk("R6", "words within budget", 64'(wordCount), 64'd5);
    chk("R6", "oldest kept counter", 64'(firstCnt), 64'd4);

    curTag = "R9/R3";
    startCount();
    doFlush();
    chk("R9", "flushDone", 64'(flushDone), 64'd1);
    chk("R9", "remaining words", 64'(wordCount), 64'd2);
    chk("R3", "saturated counter", 64'(lastCnt), 64'd7);

    // R12 events appended during a flush
    curTag = "R12";
    sendEvt(2, 0, 4, 8'h61);
    @(negedge clk);
    pfWarn = 1'b1; evtValid = 1'b1; evtRail = 2'd2; evtClass = 2'd0; evtSev = 3'd4; evtStatus = 8'h62;
    startCount();
    sendEvt(2, 0, 5, 8'h63);
    sendEvt(2, 0, 6, 8'h64);
    sendEvt(2, 0, 7, 8'h65);
    idle(12);
    pfWarn = 1'b0;
    idle(2);
    chk("R12", "appended words drained", 64'(wordCount), 64'd5);
    chk("R12", "flushDone", 64'(flushDone), 64'd1);

    // R12 drop when full during a flush
    for (int i = 0; i < SLOTS; i++) sendEvt(3, 2, 6, 8'h70 + i);
    @(negedge clk);
    evtValid = 1'b0; pfWarn = 1'b1;
    sendEvt(3, 2, 6, 8'h7F);
    idle(12);
    pfWarn = 1'b0;
    idle(2);
    chk("R12", "dropped event not pending", 64'(lostCount), 64'd2);
    doFlush();

    // R7 header pinned
    curTag = "R7";
    hwVersion = 8'h11; fwVersion = 8'h22; serialNum = 32'hDEAD_BEEF;
    sendEvt(0, 1, 4, 8'h90); idle(1);
    lastHdr = '0;
    doFlush();
    chk("R7", "header unchanged", 64'(lastHdr), 64'({1'b1, (RW-1)'({32'h1234_5678, 8'h3C, 8'hA5})}));

    idle(4);
    finishRun();
  end

endmodule